// File: doc/BRIEF.md
# Software and Pin Reset Sequencer

This block drives the active-low reset lines for a processor, its coprocessor, the processor peripherals, the coprocessor-side peripherals and an external reset pin. Software issues a command on a fast bus clock with a single-cycle write strobe and three request bits: processor reset, peripheral reset and external pin pulse. Any combination of these bits may be set in one write. A separate level input, the coprocessor-peripheral enable, holds the coprocessor-side peripherals in reset while it is 0. The command is carried into a slow-clock sequencer, which times the reset and reports a reset-type code and a busy flag.

The slow-clock sequencer is one state machine with four states. ST_IDLE waits. It moves to ST_SW_RUN when a command arrives, and this move wins over a user reset. It moves to ST_USR_HOLD when a qualified low level is seen on the pin. ST_SW_RUN lasts three slow cycles and then returns to ST_IDLE. ST_USR_HOLD moves to ST_USR_START once the synchronized pin reads high. ST_USR_START is a three-cycle startup delay that returns to ST_IDLE. A separate counter times the pulse on the external pin. While that counter runs, and for three slow cycles after it stops, a low level on the pin cannot start a user reset. This keeps the block's own pulse from being taken as a user reset.

Top module: `rst_sequencer`

## Requirements
- R1: A write with `wr_en`=1 and at least one of `wr_proc`, `wr_per` or `wr_ext` set starts a software reset. The command reaches the slow clock through a two-flop synchronizer, and the sequencer then stays in its run state for 3 slow cycles. A requested `proc_rst_n` or `periph_rst_n` is low, counted on slow falling edges, for 5 or 6 slow cycles in total.
- R2: A requested `proc_rst_n` or `periph_rst_n` goes low on the first bus-clock edge after the write. It returns high only just after a rising edge of `slow_clk`.
- R3: When `wr_ext`=1, `ext_rst_out_n` is low for exactly 2^(`ext_len`+1) slow cycles. Without `wr_ext`, the pin stays high.
- R4: With `urst_en`=1 and the pin output looped back to `ext_rst_in_n`, the block's own pulse does not cause a user reset. `coproc_rst_n` and `proc_rst_n` stay high, and `rst_type` is unchanged.
- R5: `rst_type` is 0 after power-up. It becomes 3 after a command that includes `wr_proc`. It is left unchanged by commands without `wr_proc`. It becomes 4 when a user reset starts.
- R6: `busy` rises on the bus edge after an accepted write and clears after the software reset ends. Writes made while `busy`=1 are ignored. A write with no request bit set is also ignored and does not set `busy`.
- R7: While `cp_en`=0, `cpp_rst_n` is low and `proc_rst_n` and `periph_rst_n` stay high.
- R8: With `urst_en`=1, a low level on `ext_rst_in_n` applied just after a slow falling edge pulls `proc_rst_n`, `coproc_rst_n`, `periph_rst_n` and `cpp_rst_n` low on the third slow rising edge, and not before. With `urst_en`=0, the low level has no effect.
- R9: After `ext_rst_in_n` rises, the user reset outputs return high on the sixth slow rising edge. This is two edges of resynchronization, one to leave the hold state, and three of startup.
- R10: While `por_n`=0, every reset output is low, asynchronously to both clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast command clock |
| slow_clk | input | 1 | Slow sequencing clock |
| por_n | input | 1 | Global asynchronous reset, active low |
| wr_en | input | 1 | Command write strobe (bus clock) |
| wr_proc | input | 1 | Request processor reset |
| wr_per | input | 1 | Request peripheral reset |
| wr_ext | input | 1 | Request external pin pulse |
| cp_en | input | 1 | Coprocessor-peripheral enable; 0 holds them in reset |
| ext_len | input | LEN_W | Pin pulse length field, 2^(ext_len+1) slow cycles |
| urst_en | input | 1 | Enables user reset from the pin |
| ext_rst_in_n | input | 1 | External reset pin level |
| proc_rst_n | output | 1 | Processor reset, active low |
| coproc_rst_n | output | 1 | Coprocessor reset, active low |
| periph_rst_n | output | 1 | Processor peripheral reset, active low |
| cpp_rst_n | output | 1 | Coprocessor peripheral reset, active low |
| ext_rst_out_n | output | 1 | External pin drive, active low |
| rst_type | output | 3 | Last reset cause: 0 general, 3 software, 4 user |
| busy | output | 1 | Command in progress |

## Verification
The bench loops the pin output back to the pin input while user reset is enabled. A design without the self-pulse mask would enter a user reset and report type 4. It sends a processor request while a peripheral-only command is still busy. A design that fails to lock out such writes would pulse the processor and record type 3. Peripheral-only and pin-only commands check that `rst_type` holds its previous code, which catches a design that updates the type on every command. The bench counts slow edges through the user-reset entry and exit, and checks release alignment against the slow clock. An off-by-one in the synchronizer or startup count, or a release driven from the bus domain, shows up as a wrong edge count.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SW_RUN,
        ST_USR_HOLD,
        ST_USR_START
    } seq_state_t;

    localparam logic [2:0] RT_GENERAL  = 3'd0;
    localparam logic [2:0] RT_SOFTWARE = 3'd3;
    localparam logic [2:0] RT_USER     = 3'd4;

    localparam int SW_CYCLES      = 3;
    localparam int STARTUP_CYCLES = 3;
    localparam int MASK_TAIL      = 3;
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rstseq_bus_cmd.sv
module rstseq_bus_cmd (
    input  logic bus_clk,
    input  logic por_n,
    input  logic wr_en,
    input  logic wr_proc,
    input  logic wr_per,
    input  logic wr_ext,
    input  logic ack_sync,
    input  logic done_sync,
    output logic req_tgl,
    output logic cmd_proc,
    output logic cmd_per,
    output logic cmd_ext,
    output logic hold_proc,
    output logic hold_per,
    output logic busy
);
    logic ack_last, done_last, accept;

    assign accept = wr_en && !busy && (wr_proc || wr_per || wr_ext);

    always_ff @(posedge bus_clk or negedge por_n) begin
        if (!por_n) begin
            ack_last  <= 1'b0;
            done_last <= 1'b0;
            req_tgl   <= 1'b0;
            cmd_proc  <= 1'b0;
            cmd_per   <= 1'b0;
            cmd_ext   <= 1'b0;
            hold_proc <= 1'b0;
            hold_per  <= 1'b0;
            busy      <= 1'b0;
        end else begin
            ack_last  <= ack_sync;
            done_last <= done_sync;
            if (accept) begin
                busy      <= 1'b1;
                req_tgl   <= ~req_tgl;
                cmd_proc  <= wr_proc;
                cmd_per   <= wr_per;
                cmd_ext   <= wr_ext;
                hold_proc <= wr_proc;
                hold_per  <= wr_per;
            end else begin
                if (ack_sync != ack_last) begin
                    hold_proc <= 1'b0;
                    hold_per  <= 1'b0;
                end
                if (done_sync != done_last) busy <= 1'b0;
            end
        end
    end

    AST_IGNORE_BUSY: assert property (@(posedge bus_clk) disable iff (!por_n)
        (busy && wr_en) |=> $stable(req_tgl)); // R6

    AST_HOLD_FROM_WRITE: assert property (@(posedge bus_clk) disable iff (!por_n)
        $rose(hold_proc) |-> $past(wr_en && wr_proc)); // R2
endmodule

// File: rtl/rstseq_slow_fsm.sv
module rstseq_slow_fsm
    import rstseq_pkg::*;
#(
    parameter int LEN_W = 3
) (
    input  logic             slow_clk,
    input  logic             por_n,
    input  logic             req_lvl,
    input  logic             cmd_proc,
    input  logic             cmd_per,
    input  logic             cmd_ext,
    input  logic [LEN_W-1:0] ext_len,
    input  logic             urst_en,
    input  logic             pin_sync,
    output logic             ack_tgl,
    output logic             done_tgl,
    output logic             sw_proc_act,
    output logic             sw_per_act,
    output logic             usr_act,
    output logic             ext_drive_n,
    output logic [2:0]       rst_type
);
    localparam int CW = (1 << LEN_W) + 2;

    seq_state_t    state, nxt;
    logic [1:0]    cnt;
    logic [1:0]    tail;
    logic [CW-1:0] ext_cnt;
    logic          req_last, pend, start, go, mask, usr_low;
    logic          lat_proc, lat_per;

    assign start   = req_lvl ^ req_last;
    assign go      = start || pend;
    assign mask    = (ext_cnt != '0) || (tail != '0);
    assign usr_low = urst_en && !pin_sync && !mask;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (go) nxt = ST_SW_RUN;
                          else if (usr_low) nxt = ST_USR_HOLD;
            ST_SW_RUN:    if (cnt == 2'(SW_CYCLES - 1)) nxt = ST_IDLE;
            ST_USR_HOLD:  if (pin_sync) nxt = ST_USR_START;
            ST_USR_START: if (cnt == 2'(STARTUP_CYCLES - 1)) nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge slow_clk or negedge por_n) begin
        if (!por_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            tail     <= '0;
            ext_cnt  <= '0;
            req_last <= 1'b0;
            pend     <= 1'b0;
            lat_proc <= 1'b0;
            lat_per  <= 1'b0;
            ack_tgl  <= 1'b0;
            done_tgl <= 1'b0;
            rst_type <= RT_GENERAL;
        end else begin
            state    <= nxt;
            req_last <= req_lvl;
            cnt      <= (nxt != state) ? 2'd0 : cnt + 2'd1;
            if (state == ST_IDLE && go) pend <= 1'b0;
            else if (start)             pend <= 1'b1;
            if (state == ST_IDLE && go) begin
                lat_proc <= cmd_proc;
                lat_per  <= cmd_per;
                ack_tgl  <= ~ack_tgl;
                if (cmd_proc) rst_type <= RT_SOFTWARE;
            end
            if (state == ST_IDLE && nxt == ST_USR_HOLD) rst_type <= RT_USER;
            if (state == ST_SW_RUN && nxt == ST_IDLE) done_tgl <= ~done_tgl;
            if (state == ST_IDLE && go && cmd_ext)
                ext_cnt <= CW'(1) << (int'(ext_len) + 1);
            else if (ext_cnt != '0)
                ext_cnt <= ext_cnt - CW'(1);
            if (ext_cnt == CW'(1))  tail <= 2'(MASK_TAIL);
            else if (tail != '0)    tail <= tail - 2'd1;
        end
    end

    always_comb begin
        sw_proc_act = (state == ST_SW_RUN) && lat_proc;
        sw_per_act  = (state == ST_SW_RUN) && lat_per;
        usr_act     = (state == ST_USR_HOLD) || (state == ST_USR_START);
        ext_drive_n = (ext_cnt == '0);
    end

    AST_SW_THREE: assert property (@(posedge slow_clk) disable iff (!por_n)
        $rose(state == ST_SW_RUN) |=> (state == ST_SW_RUN) ##1 (state == ST_SW_RUN) ##1 (state != ST_SW_RUN)); // R1

    AST_NO_SELF_USER: assert property (@(posedge slow_clk) disable iff (!por_n)
        $rose(state == ST_USR_HOLD) |-> $past(ext_cnt == '0 && tail == '0)); // R4

    AST_TYPE_CAUSE: assert property (@(posedge slow_clk) disable iff (!por_n)
        !$stable(rst_type) |-> (rst_type == RT_USER) || (rst_type == RT_SOFTWARE && lat_proc)); // R5

    AST_STARTUP_THREE: assert property (@(posedge slow_clk) disable iff (!por_n)
        $rose(state == ST_USR_START) |=> (state == ST_USR_START) ##1 (state == ST_USR_START) ##1 (state == ST_IDLE)); // R9
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer #(
    parameter int LEN_W     = 3,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             bus_clk,
    input  logic             slow_clk,
    input  logic             por_n,
    input  logic             wr_en,
    input  logic             wr_proc,
    input  logic             wr_per,
    input  logic             wr_ext,
    input  logic             cp_en,
    input  logic [LEN_W-1:0] ext_len,
    input  logic             urst_en,
    input  logic             ext_rst_in_n,
    output logic             proc_rst_n,
    output logic             coproc_rst_n,
    output logic             periph_rst_n,
    output logic             cpp_rst_n,
    output logic             ext_rst_out_n,
    output logic [2:0]       rst_type,
    output logic             busy
);
    logic req_tgl, req_lvl, ack_tgl, ack_sync, done_tgl, done_sync, pin_sync;
    logic cmd_proc, cmd_per, cmd_ext, hold_proc, hold_per;
    logic sw_proc_act, sw_per_act, usr_act, ext_drive_n;

    rstseq_bus_cmd u_bus (
        .bus_clk(bus_clk), .por_n(por_n), .wr_en(wr_en),
        .wr_proc(wr_proc), .wr_per(wr_per), .wr_ext(wr_ext),
        .ack_sync(ack_sync), .done_sync(done_sync), .req_tgl(req_tgl),
        .cmd_proc(cmd_proc), .cmd_per(cmd_per), .cmd_ext(cmd_ext),
        .hold_proc(hold_proc), .hold_per(hold_per), .busy(busy)
    );

    rstseq_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b0)) u_req_sync (
        .clk(slow_clk), .rst_n(por_n), .d(req_tgl), .q(req_lvl));
    rstseq_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b0)) u_ack_sync (
        .clk(bus_clk), .rst_n(por_n), .d(ack_tgl), .q(ack_sync));
    rstseq_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b0)) u_done_sync (
        .clk(bus_clk), .rst_n(por_n), .d(done_tgl), .q(done_sync));
    rstseq_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b1)) u_pin_sync (
        .clk(slow_clk), .rst_n(por_n), .d(ext_rst_in_n), .q(pin_sync));

    rstseq_slow_fsm #(.LEN_W(LEN_W)) u_fsm (
        .slow_clk(slow_clk), .por_n(por_n), .req_lvl(req_lvl),
        .cmd_proc(cmd_proc), .cmd_per(cmd_per), .cmd_ext(cmd_ext),
        .ext_len(ext_len), .urst_en(urst_en), .pin_sync(pin_sync),
        .ack_tgl(ack_tgl), .done_tgl(done_tgl), .sw_proc_act(sw_proc_act),
        .sw_per_act(sw_per_act), .usr_act(usr_act),
        .ext_drive_n(ext_drive_n), .rst_type(rst_type)
    );

    assign proc_rst_n    = por_n && !(hold_proc || sw_proc_act || usr_act);
    assign periph_rst_n  = por_n && !(hold_per || sw_per_act || usr_act);
    assign coproc_rst_n  = por_n && !usr_act;
    assign cpp_rst_n     = por_n && cp_en && !usr_act;
    assign ext_rst_out_n = por_n && ext_drive_n;

    always_comb begin
        if (!por_n) AST_POR_LOW: assert (!proc_rst_n && !periph_rst_n && !coproc_rst_n && !cpp_rst_n && !ext_rst_out_n); // R10
    end
endmodule

// File: tb/sim_rst_sequencer.sv
`timescale 1ns/1ps
module sim_rst_sequencer;
    localparam int CLK_PERIOD  = 10;
    localparam int SLOW_PERIOD = 70;
    localparam int LEN_W       = 3;

    logic bclk = 1'b0, sclk = 1'b0, por_n = 1'b0;
    logic wr_en = 0, wr_proc = 0, wr_per = 0, wr_ext = 0, cp_en = 1, urst_en = 0;
    logic [LEN_W-1:0] ext_len = '0;
    logic pin_drv = 1'b1, loopback = 1'b0, pin;
    logic proc_rst_n, coproc_rst_n, periph_rst_n, cpp_rst_n, ext_rst_out_n, busy;
    logic [2:0] rst_type;

    int errors = 0, checks = 0;
    int pl = 0, rl = 0, cl = 0, el = 0;
    bit mon_en = 0, done = 0;
    logic prev_proc = 1'b0;
    realtime last_rise = 0;
    logic [2:0] exp_type;

    always #(CLK_PERIOD/2) bclk = ~bclk;
    always #(SLOW_PERIOD/2) sclk = ~sclk;
    assign pin = loopback ? ext_rst_out_n : pin_drv;

    rst_sequencer #(.LEN_W(LEN_W)) u0 (
        .bus_clk(bclk), .slow_clk(sclk), .por_n(por_n), .wr_en(wr_en),
        .wr_proc(wr_proc), .wr_per(wr_per), .wr_ext(wr_ext), .cp_en(cp_en),
        .ext_len(ext_len), .urst_en(urst_en), .ext_rst_in_n(pin),
        .proc_rst_n(proc_rst_n), .coproc_rst_n(coproc_rst_n),
        .periph_rst_n(periph_rst_n), .cpp_rst_n(cpp_rst_n),
        .ext_rst_out_n(ext_rst_out_n), .rst_type(rst_type), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int pulse_len(input int len);
        return 1 << (len + 1);
    endfunction

    function automatic logic [2:0] next_type(input logic [2:0] prev, input bit p);
        return p ? 3'd3 : prev;
    endfunction

    always @(posedge sclk) last_rise = $realtime;
    always @(negedge sclk) begin
        if (!proc_rst_n)    pl++;
        if (!periph_rst_n)  rl++;
        if (!coproc_rst_n)  cl++;
        if (!ext_rst_out_n) el++;
    end
    always @(negedge bclk) begin
        if (mon_en && !prev_proc && proc_rst_n)
            chk(($realtime - last_rise) <= CLK_PERIOD, "R2 release aligned to slow edge",
                int'($realtime - last_rise), CLK_PERIOD);
        prev_proc = proc_rst_n;
    end

    task automatic clear_counts();
        pl = 0; rl = 0; cl = 0; el = 0;
    endtask

    task automatic do_write(input bit p, input bit q, input bit e);
        @(negedge bclk);
        wr_en = 1; wr_proc = p; wr_per = q; wr_ext = e;
        @(negedge bclk);
        wr_en = 0; wr_proc = 0; wr_per = 0; wr_ext = 0;
    endtask

    task automatic wait_idle();
        do @(negedge bclk);
        while (busy || !ext_rst_out_n || !proc_rst_n || !periph_rst_n);
        repeat (5) @(negedge sclk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        #(CLK_PERIOD * 3);
        // R10: power-up holds everything low
        chk(!proc_rst_n && !periph_rst_n && !coproc_rst_n && !cpp_rst_n && !ext_rst_out_n,
            "R10 outputs low in reset", int'(proc_rst_n), 0);
        @(negedge sclk); por_n = 1;
        repeat (3) @(negedge sclk);
        chk(rst_type == 3'd0, "R5 type after power-up", int'(rst_type), 0);
        chk(busy == 0, "R6 idle after reset", int'(busy), 0);
        chk(proc_rst_n && coproc_rst_n && periph_rst_n && cpp_rst_n && ext_rst_out_n,
            "R10 outputs released", 0, 1);
        exp_type = 3'd0;
        mon_en = 1;

        // R6: empty write ignored
        do_write(0, 0, 0);
        chk(busy == 0, "R6 empty write ignored", int'(busy), 0);

        // directed: processor only
        clear_counts();
        do_write(1, 0, 0);
        chk(!proc_rst_n, "R2 proc asserted after write", int'(proc_rst_n), 0);
        chk(busy, "R6 busy after write", int'(busy), 1);
        wait_idle();
        chk(pl >= 5 && pl <= 6, "R1 proc low length", pl, 5);
        chk(rl == 0, "R1 periph untouched", rl, 0);
        exp_type = next_type(exp_type, 1);
        chk(rst_type == exp_type, "R5 type after proc cmd", int'(rst_type), int'(exp_type));

        // random mixture
        for (int i = 0; i < 16; i++) begin
            bit p, q, e;
            int len;
            int code;
            code = int'($urandom_range(1, 7));
            p = code[0]; q = code[1]; e = code[2];
            len = int'($urandom_range(0, 3));
            ext_len = LEN_W'(len);
            clear_counts();
            do_write(p, q, e);
            chk(proc_rst_n == !p, "R2 proc follows request", int'(proc_rst_n), int'(!p));
            chk(periph_rst_n == !q, "R2 periph follows request", int'(periph_rst_n), int'(!q));
            wait_idle();
            if (p) chk(pl >= 5 && pl <= 6, "R1 proc low length", pl, 5);
            else   chk(pl == 0, "R1 proc not requested", pl, 0);
            if (q) chk(rl >= 5 && rl <= 6, "R1 periph low length", rl, 5);
            else   chk(rl == 0, "R1 periph not requested", rl, 0);
            chk(el == (e ? pulse_len(len) : 0), "R3 pin pulse length", el, e ? pulse_len(len) : 0);
            exp_type = next_type(exp_type, p);
            chk(rst_type == exp_type, "R5 type tracking", int'(rst_type), int'(exp_type));
        end

        // R6: write during busy ignored
        exp_type = 3'd0;
        urst_en = 1; pin_drv = 0;
        repeat (4) @(negedge sclk);
        pin_drv = 1;
        repeat (10) @(negedge sclk);
        urst_en = 0;
        exp_type = 3'd4;
        clear_counts();
        do_write(0, 1, 0);
        do_write(1, 0, 0);
        wait_idle();
        chk(pl == 0, "R6 proc write while busy ignored", pl, 0);
        chk(rst_type == exp_type, "R6 type unchanged by ignored write", int'(rst_type), int'(exp_type));

        // R7: coprocessor peripheral enable
        @(negedge bclk); cp_en = 0;
        @(negedge bclk);
        chk(!cpp_rst_n, "R7 cpp reset low", int'(cpp_rst_n), 0);
        chk(proc_rst_n && periph_rst_n, "R7 others untouched", int'(periph_rst_n), 1);
        cp_en = 1;
        @(negedge bclk);
        chk(cpp_rst_n, "R7 cpp released", int'(cpp_rst_n), 1);

        // R8 disabled: no effect
        urst_en = 0;
        clear_counts();
        @(negedge sclk); pin_drv = 0;
        repeat (6) @(negedge sclk);
        chk(pl == 0 && cl == 0, "R8 disabled pin ignored", cl, 0);
        pin_drv = 1;
        repeat (4) @(negedge sclk);

        // R8/R9 user reset timing
        urst_en = 1;
        @(negedge sclk); pin_drv = 0;
        repeat (2) @(posedge sclk);
        @(negedge sclk);
        chk(proc_rst_n, "R8 not yet asserted at edge 2", int'(proc_rst_n), 1);
        @(negedge sclk);
        chk(!proc_rst_n && !coproc_rst_n && !periph_rst_n && !cpp_rst_n,
            "R8 user reset asserted at edge 3", int'(coproc_rst_n), 0);
        chk(rst_type == 3'd4, "R5 user type", int'(rst_type), 4);
        repeat (3) @(negedge sclk);
        pin_drv = 1;
        repeat (5) @(negedge sclk);
        chk(!proc_rst_n, "R9 still held at edge 5", int'(proc_rst_n), 0);
        @(negedge sclk);
        chk(proc_rst_n && coproc_rst_n && periph_rst_n && cpp_rst_n,
            "R9 released at edge 6", int'(proc_rst_n), 1);
        repeat (4) @(negedge sclk);

        // R4: loopback of own pulse, after a processor command sets type 3
        do_write(1, 0, 0);
        wait_idle();
        exp_type = 3'd3;
        loopback = 1; ext_len = LEN_W'(2);
        clear_counts();
        do_write(0, 0, 1);
        wait_idle();
        repeat (6) @(negedge sclk);
        chk(el == 8, "R3 looped pulse length", el, 8);
        chk(cl == 0 && pl == 0, "R4 own pulse not user reset", cl, 0);
        chk(rst_type == exp_type, "R4 type unchanged", int'(rst_type), int'(exp_type));
        loopback = 0; urst_en = 0;

        finish_run();
    end
endmodule